// File: doc/BRIEF.md
# Packet-Stream Register File Slave

This block sits on a 32-bit packet stream bus as one of several slaves and serves a small bank of 32-bit registers. Every incoming packet opens with a routing header on the start-of-packet beat. The header carries a four-bit type code, a four-bit tag and a length. When the type code names this slave, the next beat is a command word. Bit 31 of the command word selects write (1) or read (0), and bits 23:2 hold a word-aligned byte address. A write command is followed by one data beat, which lands in the addressed register. A read command ends the packet, and the block answers it with a two-beat response packet.

The response leaves on a separate output stream. The block raises a request line and waits until the downstream side drops its busy input. It then sends a header beat that echoes the request tag, followed at once by the data beat, which carries end-of-packet. From the beat after a read command until the last response beat, the block holds its own busy output high, so upstream sends no new command into it.

Top module: `pktreg_slave`

## Requirements
- R1: After the asynchronous reset (rst_n low), out_req, out_en, out_eop and in_busy are low, and every register reads as zero.
- R2: A packet is decoded only when its start-of-packet beat (in_en and in_sop high, in_eop low) has type bits 31:28 equal to 4'b0010. Packets with any other type code cause no register change and no response.
- R3: A beat without in_sop never starts a decode, even when its bits 31:28 are 4'b0010.
- R4: In the command word, bit 31 = 1 means write. The following data beat is stored at register index address[23:2]. Address bits 1:0 are ignored, and each write changes at most one register.
- R5: In the command word, bit 31 = 0 means read. The block answers with a header beat {4'b0010, tag, 24'd1} and then a data beat that holds the register value.
- R6: The block holds out_req high for the whole response. It sends the header beat only in the cycle after one in which out_busy was low, and the data beat in the next cycle. While it waits, out_data holds the header steady.
- R7: out_eop is high only together with out_en, and only on the data beat of a response.
- R8: in_busy is high from the cycle after a read command until the response data beat has been sent. Command beats offered during that time have no effect.
- R9: A write to an index at or above NUM_REGS is dropped and does not alias onto a lower register. A read of such an index returns zero.
- R10: The response header carries the tag taken from bits 27:24 of the request's start-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Incoming stream word |
| in_en | input | 1 | Incoming word valid |
| in_sop | input | 1 | First beat of an incoming packet |
| in_eop | input | 1 | Last beat of an incoming packet |
| in_busy | output | 1 | Back-pressure to the upstream side while a response is outstanding |
| out_req | output | 1 | Request for the outgoing stream |
| out_data | output | 32 | Outgoing stream word |
| out_en | output | 1 | Outgoing word valid |
| out_eop | output | 1 | Last beat of an outgoing packet |
| out_busy | input | 1 | Downstream busy; holds the response back |

## Verification
Assertions check the response handshake on every cycle. The header may only follow a cycle with out_busy low, the data beat must follow the header directly, out_data must stay steady while the block waits, out_eop needs out_en, and in_busy must cover any active request. They also check that a non-start beat keeps the decoder idle and that a write decodes to at most one register. Only the bench scenarios can show the values that move through the block: that stored data reads back at the right index, that address bits 1:0 are ignored, that foreign types, stray data beats and out-of-range addresses change nothing, that tags are echoed, and that commands sent while busy are dropped.

// File: rtl/pktreg_pkg.sv
package pktreg_pkg;

    localparam int          WORD_W      = 32;
    localparam int          ADDR_W      = 22;          // word index field, bits 23:2
    localparam logic [3:0]  SLAVE_TYPE  = 4'b0010;
    localparam logic [23:0] RESP_LEN    = 24'd1;

    typedef enum logic [1:0] {
        C_IDLE,
        C_CMD,
        C_WDATA,
        C_RESP
    } ctrl_state_e;

    typedef enum logic [1:0] {
        R_IDLE,
        R_WAIT,
        R_HDR,
        R_DAT
    } resp_state_e;

endpackage

// File: rtl/pktreg_ctrl.sv
module pktreg_ctrl
    import pktreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_en,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              resp_last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [3:0]        tag,
    output logic              in_busy
);

    typedef struct packed {
        ctrl_state_e       state;
        logic [3:0]        tag;
        logic [ADDR_W-1:0] addr;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    logic [1:0] unused_low_bits;
    assign unused_low_bits = in_data[1:0];

    always_comb begin
        r_d      = r_q;
        wr_en    = 1'b0;
        rd_start = 1'b0;
        unique case (r_q.state)
            C_IDLE: begin
                if (in_en && in_sop && !in_eop && in_data[31:28] == SLAVE_TYPE) begin
                    r_d.tag   = in_data[27:24];
                    r_d.state = C_CMD;
                end
            end
            C_CMD: begin
                if (in_en) begin
                    r_d.addr = in_data[23:2];
                    if (in_data[31]) begin
                        r_d.state = in_eop ? C_IDLE : C_WDATA;
                    end else begin
                        rd_start  = 1'b1;
                        r_d.state = C_RESP;
                    end
                end
            end
            C_WDATA: begin
                if (in_en) begin
                    wr_en     = 1'b1;
                    r_d.state = C_IDLE;
                end
            end
            C_RESP: begin
                if (resp_last) begin
                    r_d.state = C_IDLE;
                end
            end
            default: r_d.state = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: C_IDLE, tag: '0, addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_addr = r_q.addr;
    assign rd_addr = in_data[23:2];
    assign tag     = r_q.tag;
    assign in_busy = (r_q.state == C_RESP);

    // R3: a beat without start-of-packet leaves an idle decoder idle
    a_r3_no_decode_without_sop: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == C_IDLE && !in_sop) |=> (r_q.state == C_IDLE));

endmodule

// File: rtl/pktreg_store.sv
module pktreg_store
    import pktreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [WORD_W-1:0]   regs_q [NUM_REGS];
    logic [WORD_W-1:0]   regs_d [NUM_REGS];
    logic [NUM_REGS-1:0] hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign hit[i] = wr_en && (wr_addr == ADDR_W'(i));

        always_comb begin
            regs_d[i] = hit[i] ? wr_data : regs_q[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    logic rd_in_range;
    assign rd_in_range = (rd_addr < ADDR_W'(NUM_REGS));
    assign rd_data     = rd_in_range ? regs_q[rd_addr[IDX_W-1:0]] : '0;

    // R4: a write updates at most one register
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/pktreg_resp.sv
module pktreg_resp
    import pktreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        tag,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              out_busy,
    output logic              out_req,
    output logic [WORD_W-1:0] out_data,
    output logic              out_en,
    output logic              out_eop,
    output logic              last
);

    typedef struct packed {
        resp_state_e       state;
        logic [3:0]        tag;
        logic [WORD_W-1:0] data;
    } resp_regs_t;

    resp_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            R_IDLE: begin
                if (start) begin
                    r_d.tag   = tag;
                    r_d.data  = rd_data;
                    r_d.state = R_WAIT;
                end
            end
            R_WAIT:  if (!out_busy) r_d.state = R_HDR;
            R_HDR:   r_d.state = R_DAT;
            R_DAT:   r_d.state = R_IDLE;
            default: r_d.state = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: R_IDLE, tag: '0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_req  = (r_q.state != R_IDLE);
    assign out_en   = (r_q.state == R_HDR) || (r_q.state == R_DAT);
    assign out_eop  = (r_q.state == R_DAT);
    assign last     = (r_q.state == R_DAT);
    assign out_data = (r_q.state == R_DAT)  ? r_q.data :
                      (r_q.state == R_IDLE) ? '0 :
                      {SLAVE_TYPE, r_q.tag, RESP_LEN};

    // R6: the header only follows a waiting cycle with downstream not busy
    a_r6_hdr_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == R_HDR) |-> $past(r_q.state == R_WAIT && !out_busy));

    // R6: the data beat directly follows the header beat
    a_r6_data_follows_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == R_HDR) |=> (out_en && out_eop));

    // R6: while held back, the request stays up and the word stays steady
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == R_WAIT && out_busy) |=> (out_req && $stable(out_data)));

    // R7: end-of-packet only accompanies a valid beat
    a_r7_eop_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_en);

endmodule

// File: rtl/pktreg_slave.sv
module pktreg_slave
    import pktreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] in_data,
    input  logic        in_en,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        in_busy,
    output logic        out_req,
    output logic [31:0] out_data,
    output logic        out_en,
    output logic        out_eop,
    input  logic        out_busy
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              rd_start;
    logic [ADDR_W-1:0] rd_addr;
    logic [3:0]        tag;
    logic [WORD_W-1:0] rd_data;
    logic              resp_last;

    pktreg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_en     (in_en),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .resp_last (resp_last),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_start  (rd_start),
        .rd_addr   (rd_addr),
        .tag       (tag),
        .in_busy   (in_busy)
    );

    pktreg_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pktreg_resp u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_start),
        .tag      (tag),
        .rd_data  (rd_data),
        .out_busy (out_busy),
        .out_req  (out_req),
        .out_data (out_data),
        .out_en   (out_en),
        .out_eop  (out_eop),
        .last     (resp_last)
    );

    // R8: upstream is held off whenever a response is outstanding
    a_r8_busy_covers_resp: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> in_busy);

endmodule

// File: tb/pktreg_slave_bench.sv
module pktreg_slave_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_en = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_busy;
    logic        out_req;
    logic [31:0] out_data;
    logic        out_en;
    logic        out_eop;
    logic        out_busy = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pktreg_slave #(.NUM_REGS(16)) u_pktreg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_en    (in_en),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_busy  (in_busy),
        .out_req  (out_req),
        .out_data (out_data),
        .out_en   (out_en),
        .out_eop  (out_eop),
        .out_busy (out_busy)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] route_hdr(input logic [3:0] typ, input logic [3:0] tg);
        return {typ, tg, 24'd2};
    endfunction

    function automatic logic [31:0] cmd_word(input bit wr, input logic [23:0] byte_addr);
        return {wr, 7'd0, byte_addr};
    endfunction

    function automatic logic [31:0] resp_hdr(input logic [3:0] tg);
        return {4'b0010, tg, 24'd1};
    endfunction

    task automatic beat(input logic [31:0] d, input bit sop, input bit eop);
        @(negedge clk);
        in_data = d; in_en = 1'b1; in_sop = sop; in_eop = eop;
    endtask

    task automatic quiet();
        @(negedge clk);
        in_en = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    endtask

    task automatic write_reg(input logic [3:0] typ, input logic [23:0] byte_addr, input logic [31:0] val);
        beat(route_hdr(typ, 4'h0), 1'b1, 1'b0);
        beat(cmd_word(1'b1, byte_addr), 1'b0, 1'b0);
        beat(val, 1'b0, 1'b1);
        quiet();
    endtask

    // Sends a read and checks the whole response; optionally offers a
    // write packet while the block is busy.
    task automatic read_check(input string req, input logic [3:0] tg, input logic [23:0] byte_addr,
                              input logic [31:0] exp, input int hold, input bit inject);
        int waited;
        out_busy = (hold > 0);
        beat(route_hdr(4'b0010, tg), 1'b1, 1'b0);
        beat(cmd_word(1'b0, byte_addr), 1'b0, 1'b1);
        quiet();
        chk("R8", "in_busy after read cmd", {31'd0, in_busy}, 32'd1);
        chk("R6", "out_req raised", {31'd0, out_req}, 32'd1);
        chk("R6", "no beat before grant", {31'd0, out_en}, 32'd0);
        for (int k = 0; k < hold; k++) begin
            chk("R6", "held while busy", {30'd0, out_en, out_req}, 32'd1);
            chk("R6", "header steady while busy", out_data, resp_hdr(tg));
            chk("R8", "in_busy while waiting", {31'd0, in_busy}, 32'd1);
            if (inject && k < 3) begin
                case (k)
                    0: begin in_data = route_hdr(4'b0010, 4'h0); in_sop = 1'b1; in_eop = 1'b0; end
                    1: begin in_data = cmd_word(1'b1, 24'h00001C); in_sop = 1'b0; in_eop = 1'b0; end
                    default: begin in_data = 32'hBAD0_0007; in_sop = 1'b0; in_eop = 1'b1; end
                endcase
                in_en = 1'b1;
            end else begin
                in_en = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            end
            @(negedge clk);
        end
        in_en = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        out_busy = 1'b0;
        waited = 0;
        while (!out_en && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        chk(req, "response header", out_data, resp_hdr(tg));
        chk("R10", "echoed tag", {28'd0, out_data[27:24]}, {28'd0, tg});
        chk("R7", "no eop on header", {31'd0, out_eop}, 32'd0);
        @(negedge clk);
        chk(req, "response data", out_data, exp);
        chk("R7", "eop with en on data beat", {30'd0, out_en, out_eop}, 32'd3);
        chk("R8", "in_busy on last beat", {31'd0, in_busy}, 32'd1);
        @(negedge clk);
        chk("R6", "request dropped after response", {30'd0, out_req, out_en}, 32'd0);
        chk("R8", "in_busy released", {31'd0, in_busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "out_req", {31'd0, out_req}, 32'd0);
        chk("R1", "out_en/out_eop", {30'd0, out_en, out_eop}, 32'd0);
        chk("R1", "in_busy", {31'd0, in_busy}, 32'd0);
        read_check("R1", 4'h1, 24'h00000C, 32'h0, 0, 1'b0);
    endtask

    task automatic t_write_read();
        write_reg(4'b0010, 24'h00000C, 32'hA5A5_5A5A);
        read_check("R5", 4'h9, 24'h00000C, 32'hA5A5_5A5A, 0, 1'b0);
        write_reg(4'b0010, 24'h000000, 32'h1357_9BDF);
        read_check("R4", 4'h3, 24'h000000, 32'h1357_9BDF, 0, 1'b0);
    endtask

    task automatic t_low_bits();
        write_reg(4'b0010, 24'h00001B, 32'h600D_0006);
        read_check("R4", 4'hC, 24'h000018, 32'h600D_0006, 0, 1'b0);
    endtask

    task automatic t_foreign_type();
        write_reg(4'b0001, 24'h000014, 32'hFEED_0005);
        chk("R2", "no response to foreign type", {31'd0, out_req}, 32'd0);
        beat(route_hdr(4'b0010, 4'h0), 1'b1, 1'b1);
        beat(cmd_word(1'b1, 24'h000014), 1'b0, 1'b0);
        beat(32'hFEED_0055, 1'b0, 1'b1);
        quiet();
        read_check("R2", 4'h5, 24'h000014, 32'h0, 0, 1'b0);
    endtask

    task automatic t_stray_beats();
        beat(32'h2300_0001, 1'b0, 1'b0);
        beat(cmd_word(1'b1, 24'h000014), 1'b0, 1'b0);
        beat(32'hDEAD_BEEF, 1'b0, 1'b1);
        quiet();
        chk("R3", "no response to stray beats", {31'd0, out_req}, 32'd0);
        read_check("R3", 4'h6, 24'h000014, 32'h0, 0, 1'b0);
    endtask

    task automatic t_out_of_range();
        write_reg(4'b0010, 24'h000050, 32'h0000_0077);
        read_check("R9", 4'h7, 24'h000050, 32'h0, 0, 1'b0);
        read_check("R9", 4'h8, 24'h000010, 32'h0, 0, 1'b0);
    endtask

    task automatic t_backpressure();
        write_reg(4'b0010, 24'h000008, 32'hC0DE_0002);
        read_check("R6", 4'hA, 24'h000008, 32'hC0DE_0002, 4, 1'b0);
    endtask

    task automatic t_busy_blocks();
        read_check("R8", 4'hF, 24'h000008, 32'hC0DE_0002, 4, 1'b1);
        read_check("R8", 4'h2, 24'h00001C, 32'h0, 0, 1'b0);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_low_bits();
        t_foreign_type();
        t_stray_beats();
        t_out_of_range();
        t_backpressure();
        t_busy_blocks();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule